// File: doc/BRIEF.md
# Straddling Request Stream Packer

This block takes ordinary packetized 512-bit stream traffic, where every packet begins at dword lane 0, carries a per-dword keep mask and closes with tlast. It repacks that traffic into a continuous stream whose packet boundaries are carried only in sideband flags. A beat is 16 dwords wide. When a packet finishes at or before dword 7, the next packet may begin at dword 8 of the same output beat. From that point on, each output beat carries the upper half of the previous input beat in lanes 0-7 and the lower half of the current input beat in lanes 8-15. A single half-beat register provides that shift.

The sideband for each output beat has the following fields:
- two start flags;
- two end flags;
- a 4-bit last-dword offset for each end flag.

With straddling on, tkeep is driven all ones and tlast stays low. A configuration input can turn straddling off. In that mode every packet begins at lane 0 of a fresh beat, and tkeep and tlast follow the input. A short tail that could share its beat is parked for one clock. If the next packet's first beat does not arrive in that clock, the tail is sent on its own.

Top module: `strd_packer`

## Requirements
- R1: Every input packet of at least 4 dwords leaves the block complete, in order and with its dwords unchanged, as delineated by the start and end sideband. No output beat is valid out of reset, and no valid beat lacks both a packet start and a continuing packet.
- R2: While `straddle_en` is 1, every valid output beat has `m_tkeep` all ones and `m_tlast` 0.
- R3: A packet starts in mid-beat only at dword 8, and only when the packet before it ends in that same beat at a dword offset of 7 or less.
- R4: `m_sop[0]` is 1 in any beat where at least one packet starts. A start at dword 0 follows a beat in which the previous packet ended; a start at dword 8 continues a beat in which a packet also ends. `m_sop[1]` is 1 only when two packets start in the beat, at dwords 0 and 8, and it then comes with `m_sop[0]` and `m_eop[0]`.
- R5: `m_eop[0]` with `m_eop0_ptr` marks the last dword of the first packet ending in the beat. `m_eop[1]` with `m_eop1_ptr` marks a second ending, is set only together with `m_eop[0]`, and has a pointer in 11 to 15.
- R6: A packet whose last dword falls at offset 7 or lower is not held back waiting for a successor. If no new packet beat is accepted in the following clock, the partial beat appears on the output one clock after that, with `m_sop` = 01 if it started there, `m_eop` = 01 and the pointer at its last dword.
- R7: While `straddle_en` is 0, each packet starts at dword 0 of a new beat. `m_sop[1]` and `m_eop[1]` stay 0, `m_tlast` equals `m_eop[0]`, and `m_tkeep` is all ones except on a packet's last beat, where it has ones exactly in lanes 0 to `m_eop0_ptr`.
- R8: While `m_tvalid` is 1 and `m_tready` is 0, the output beat and all its sideband hold steady to the next clock and `s_tready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| straddle_en | input | 1 | 1 packs across half-beats, 0 gives one packet per beat; changed only while idle |
| s_tdata | input | 512 | Input beat, dword i in bits 32i+31:32i |
| s_tkeep | input | 16 | Input dword keep, contiguous from lane 0 |
| s_tlast | input | 1 | Last beat of the input packet |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted when high with s_tvalid |
| m_tdata | output | 512 | Output beat |
| m_tkeep | output | 16 | Output dword keep |
| m_tlast | output | 1 | Packet end (only with straddling off) |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream ready |
| m_sop | output | 2 | Start flags: bit 0 at least one start, bit 1 two starts |
| m_eop | output | 2 | End flags: bit 0 at least one end, bit 1 two ends |
| m_eop0_ptr | output | 4 | Last dword offset of the first ending packet |
| m_eop1_ptr | output | 4 | Last dword offset of the second ending packet |

## Verification
The assertions rely on three properties of the input traffic. Every packet is at least 4 dwords long. Its keep mask is contiguous from lane 0 and full on all but the last beat. `straddle_en` changes only when no packet is in flight. The pointer range of a second ending and the mid-beat start rule both depend on these. The stimulus draws packet lengths from 4 to 48 dwords and builds each keep mask from the length. Before the mode is switched, it drains the block until every packet has been rebuilt by the bench's unpacker.

// File: rtl/strd_pkg.sv
package strd_pkg;

  // What the current clock does with the output register and the half-beat store.
  typedef enum logic [2:0] {
    K_IDLE,   // nothing produced
    K_PASS,   // input beat goes out unshifted
    K_PARK,   // short tail stored, nothing produced yet
    K_FLUSH,  // stored tail goes out alone
    K_MERGE,  // stored tail below, new packet start above
    K_SHIFT   // shifted packet continues: store below, input low half above
  } beat_kind_e;

  // Offset of the last dword of a run of cnt dwords starting at base.
  function automatic int unsigned last_offset(int unsigned base, int unsigned cnt);
    return base + cnt - 1;
  endfunction

  // True when a run of cnt dwords fits in the lower half of a beat.
  function automatic bit fits_low(int unsigned cnt, int unsigned half_dw);
    return cnt <= half_dw;
  endfunction

endpackage

// File: rtl/strd_keep_count.sv
module strd_keep_count #(
  parameter int unsigned BEAT_DW = 16,
  parameter int unsigned CNT_W   = $clog2(BEAT_DW + 1)
) (
  input  logic [BEAT_DW-1:0] keep,
  output logic [CNT_W-1:0]   cnt
);

  always_comb begin
    cnt = '0;
    for (int i = 0; i < BEAT_DW; i++) begin
      cnt = cnt + CNT_W'(keep[i]);
    end
  end

endmodule

// File: rtl/strd_beat_mux.sv
module strd_beat_mux
  import strd_pkg::*;
#(
  parameter int unsigned DW_BITS = 32,
  parameter int unsigned BEAT_DW = 16
) (
  input  beat_kind_e                        kind,
  input  logic [BEAT_DW*DW_BITS-1:0]        in_data,
  input  logic [(BEAT_DW/2)*DW_BITS-1:0]    half_q,
  output logic [BEAT_DW*DW_BITS-1:0]        out_data
);

  localparam int unsigned HALF_W = (BEAT_DW / 2) * DW_BITS;
  localparam int unsigned DATA_W = BEAT_DW * DW_BITS;

  logic [HALF_W-1:0] in_half [2];
  logic [HALF_W-1:0] out_half [2];

  genvar h;
  generate
    for (h = 0; h < 2; h++) begin : g_half
      assign in_half[h] = in_data[h*HALF_W +: HALF_W];
      assign out_data[h*HALF_W +: HALF_W] = out_half[h];
    end
  endgenerate

  // Lower half: unshifted input, or the stored half-beat.
  always_comb begin
    unique case (kind)
      K_PASS:                   out_half[0] = in_half[0];
      K_FLUSH, K_MERGE, K_SHIFT: out_half[0] = half_q;
      default:                  out_half[0] = '0;
    endcase
  end

  // Upper half: unshifted input, or the input's lower half moved up.
  always_comb begin
    unique case (kind)
      K_PASS:           out_half[1] = in_half[1];
      K_MERGE, K_SHIFT: out_half[1] = in_half[0];
      default:          out_half[1] = '0;
    endcase
  end

  logic unused_w;
  assign unused_w = ^{DATA_W[0]};

endmodule

// File: rtl/strd_out_stage.sv
module strd_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] in_bits,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] out_bits
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      out_bits <= in_bits;
    end
  end

endmodule

// File: rtl/strd_packer.sv
module strd_packer
  import strd_pkg::*;
#(
  parameter int unsigned DW_BITS = 32,
  parameter int unsigned BEAT_DW = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          straddle_en,
  input  logic [BEAT_DW*DW_BITS-1:0]    s_tdata,
  input  logic [BEAT_DW-1:0]            s_tkeep,
  input  logic                          s_tlast,
  input  logic                          s_tvalid,
  output logic                          s_tready,
  output logic [BEAT_DW*DW_BITS-1:0]    m_tdata,
  output logic [BEAT_DW-1:0]            m_tkeep,
  output logic                          m_tlast,
  output logic                          m_tvalid,
  input  logic                          m_tready,
  output logic [1:0]                    m_sop,
  output logic [1:0]                    m_eop,
  output logic [$clog2(BEAT_DW)-1:0]    m_eop0_ptr,
  output logic [$clog2(BEAT_DW)-1:0]    m_eop1_ptr
);

  localparam int unsigned HALF_DW = BEAT_DW / 2;
  localparam int unsigned HALF_W  = HALF_DW * DW_BITS;
  localparam int unsigned DATA_W  = BEAT_DW * DW_BITS;
  localparam int unsigned PTR_W   = $clog2(BEAT_DW);
  localparam int unsigned CNT_W   = $clog2(BEAT_DW + 1);
  localparam int unsigned SB_W    = BEAT_DW + 1 + 2 + 2 + 2 * PTR_W;
  localparam int unsigned OUT_W   = DATA_W + SB_W;

  // State of the packer
  logic              pend_vld;    // a short tail waits in half_q (lanes 0..pend_cnt-1)
  logic              pend_sop;    // that tail's packet also started in it
  logic [CNT_W-1:0]  pend_cnt;
  logic              shift_act;   // a packet is in flight at dword offset 8
  logic              first_beat;  // next input beat opens a packet
  logic [HALF_W-1:0] half_q;

  // Named internal events
  logic       adv;          // output register can take a beat
  logic       take;         // input beat accepted
  logic       in_ends_low;  // input beat is a last beat of 8 dwords or fewer
  logic       out_load;
  logic       flush_evt;    // stored tail leaves alone
  logic       merge_evt;    // stored tail shares a beat with a new start
  logic       park_evt;     // short tail parked
  beat_kind_e kind;

  logic [CNT_W-1:0]   in_cnt;
  logic [DATA_W-1:0]  nx_data;
  logic [BEAT_DW-1:0] nx_keep;
  logic               nx_last;
  logic [1:0]         nx_sop, nx_eop;
  logic [PTR_W-1:0]   nx_p0, nx_p1;
  logic [OUT_W-1:0]   out_bits;

  strd_keep_count #(.BEAT_DW(BEAT_DW), .CNT_W(CNT_W)) u_cnt (
    .keep (s_tkeep),
    .cnt  (in_cnt)
  );

  assign adv         = !m_tvalid || m_tready;
  assign s_tready    = adv && !(pend_vld && !straddle_en);
  assign take        = s_tvalid && s_tready;
  assign in_ends_low = s_tlast && fits_low(32'(in_cnt), HALF_DW);

  // Per-clock decision
  always_comb begin
    kind = K_IDLE;
    if (adv) begin
      if (pend_vld) begin
        kind = (s_tvalid && straddle_en) ? K_MERGE : K_FLUSH;
      end else if (shift_act) begin
        if (s_tvalid) kind = K_SHIFT;
      end else if (s_tvalid) begin
        kind = (straddle_en && in_ends_low) ? K_PARK : K_PASS;
      end
    end
  end

  assign out_load  = kind inside {K_PASS, K_FLUSH, K_MERGE, K_SHIFT};
  assign flush_evt = (kind == K_FLUSH);
  assign merge_evt = (kind == K_MERGE);
  assign park_evt  = (kind == K_PARK);

  strd_beat_mux #(.DW_BITS(DW_BITS), .BEAT_DW(BEAT_DW)) u_mux (
    .kind     (kind),
    .in_data  (s_tdata),
    .half_q   (half_q),
    .out_data (nx_data)
  );

  // Sideband for the beat being loaded
  always_comb begin
    nx_sop  = 2'b00;
    nx_eop  = 2'b00;
    nx_p0   = '0;
    nx_p1   = '0;
    nx_keep = '1;
    nx_last = 1'b0;
    unique case (kind)
      K_PASS: begin
        nx_sop = {1'b0, first_beat};
        nx_eop = {1'b0, s_tlast};
        if (s_tlast) nx_p0 = PTR_W'(last_offset(0, 32'(in_cnt)));
        if (!straddle_en) begin
          nx_keep = s_tkeep;
          nx_last = s_tlast;
        end
      end
      K_FLUSH: begin
        nx_sop = {1'b0, pend_sop};
        nx_eop = 2'b01;
        nx_p0  = PTR_W'(last_offset(0, 32'(pend_cnt)));
      end
      K_MERGE: begin
        nx_sop = {pend_sop, 1'b1};
        nx_eop = {in_ends_low, 1'b1};
        nx_p0  = PTR_W'(last_offset(0, 32'(pend_cnt)));
        if (in_ends_low) nx_p1 = PTR_W'(last_offset(HALF_DW, 32'(in_cnt)));
      end
      K_SHIFT: begin
        nx_eop = {1'b0, in_ends_low};
        if (in_ends_low) nx_p0 = PTR_W'(last_offset(HALF_DW, 32'(in_cnt)));
      end
      default: ;
    endcase
  end

  // Control state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld   <= 1'b0;
      pend_sop   <= 1'b0;
      pend_cnt   <= '0;
      shift_act  <= 1'b0;
      first_beat <= 1'b1;
    end else begin
      if (take) first_beat <= s_tlast;
      unique case (kind)
        K_PARK: begin
          pend_vld <= 1'b1;
          pend_sop <= first_beat;
          pend_cnt <= in_cnt;
        end
        K_FLUSH: pend_vld <= 1'b0;
        K_MERGE, K_SHIFT: begin
          if (in_ends_low) begin
            pend_vld  <= 1'b0;
            shift_act <= 1'b0;
          end else if (s_tlast) begin
            pend_vld  <= 1'b1;
            pend_sop  <= 1'b0;
            pend_cnt  <= in_cnt - CNT_W'(HALF_DW);
            shift_act <= 1'b0;
          end else begin
            pend_vld  <= 1'b0;
            shift_act <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // Half-beat store: parked low half, or the upper half shifted down next beat
  always_ff @(posedge clk) begin
    if (park_evt) begin
      half_q <= s_tdata[HALF_W-1:0];
    end else if (kind == K_MERGE || kind == K_SHIFT) begin
      half_q <= s_tdata[DATA_W-1:HALF_W];
    end
  end

  strd_out_stage #(.W(OUT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (out_load),
    .in_bits  ({nx_data, nx_keep, nx_last, nx_sop, nx_eop, nx_p0, nx_p1}),
    .ready    (m_tready),
    .valid    (m_tvalid),
    .out_bits (out_bits)
  );

  assign {m_tdata, m_tkeep, m_tlast, m_sop, m_eop, m_eop0_ptr, m_eop1_ptr} = out_bits;

  logic unused_evt;
  assign unused_evt = merge_evt;

endmodule

// File: rtl/strd_packer_chk.sv
module strd_packer_chk #(
  parameter int unsigned DW_BITS = 32,
  parameter int unsigned BEAT_DW = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       straddle_en,
  input logic                       s_tready,
  input logic                       m_tvalid,
  input logic                       m_tready,
  input logic [BEAT_DW*DW_BITS-1:0] m_tdata,
  input logic [BEAT_DW-1:0]         m_tkeep,
  input logic                       m_tlast,
  input logic [1:0]                 m_sop,
  input logic [1:0]                 m_eop,
  input logic [$clog2(BEAT_DW)-1:0] m_eop0_ptr,
  input logic [$clog2(BEAT_DW)-1:0] m_eop1_ptr,
  input logic                       flush_evt
);

  localparam int unsigned PTR_W = $clog2(BEAT_DW);
  localparam logic [PTR_W-1:0] HALF_PTR = PTR_W'(BEAT_DW / 2);
  localparam logic [PTR_W-1:0] MIN_P1   = PTR_W'(BEAT_DW / 2 + 3);

  assert_keep_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    straddle_en && m_tvalid |-> (&m_tkeep) && !m_tlast);

  assert_mid_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_sop[1] |-> m_eop[0] && (m_eop0_ptr < HALF_PTR));

  assert_sop_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_sop[1] |-> m_sop[0]);

  assert_eop_pair_R5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_eop[1] |-> m_eop[0] && (m_eop1_ptr >= MIN_P1));

  assert_tail_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_evt |=> m_tvalid && m_eop == 2'b01 && (m_eop0_ptr < HALF_PTR) && !m_sop[1]);

  assert_plain_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !straddle_en && m_tvalid |-> m_sop[1] == 1'b0 && m_eop[1] == 1'b0 && m_tlast == m_eop[0]);

  assert_hold_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata) && $stable(m_tkeep)
      && $stable(m_tlast) && $stable(m_sop) && $stable(m_eop)
      && $stable(m_eop0_ptr) && $stable(m_eop1_ptr));

  assert_stall_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |-> !s_tready);

endmodule

bind strd_packer strd_packer_chk #(.DW_BITS(DW_BITS), .BEAT_DW(BEAT_DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .straddle_en (straddle_en),
  .s_tready    (s_tready),
  .m_tvalid    (m_tvalid),
  .m_tready    (m_tready),
  .m_tdata     (m_tdata),
  .m_tkeep     (m_tkeep),
  .m_tlast     (m_tlast),
  .m_sop       (m_sop),
  .m_eop       (m_eop),
  .m_eop0_ptr  (m_eop0_ptr),
  .m_eop1_ptr  (m_eop1_ptr),
  .flush_evt   (flush_evt)
);

// File: tb/strd_packer_tb.sv
module strd_packer_tb;

  localparam int BDW    = 16;
  localparam int DATA_W = 512;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              straddle_en = 1'b1;
  logic [DATA_W-1:0] s_tdata = '0;
  logic [BDW-1:0]    s_tkeep = '0;
  logic              s_tlast = 1'b0;
  logic              s_tvalid = 1'b0;
  logic              s_tready;
  logic [DATA_W-1:0] m_tdata;
  logic [BDW-1:0]    m_tkeep;
  logic              m_tlast;
  logic              m_tvalid;
  logic              m_tready = 1'b1;
  logic [1:0]        m_sop, m_eop;
  logic [3:0]        m_eop0_ptr, m_eop1_ptr;

  strd_packer u_dut (
    .clk(clk), .rst_n(rst_n), .straddle_en(straddle_en),
    .s_tdata(s_tdata), .s_tkeep(s_tkeep), .s_tlast(s_tlast),
    .s_tvalid(s_tvalid), .s_tready(s_tready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready),
    .m_sop(m_sop), .m_eop(m_eop), .m_eop0_ptr(m_eop0_ptr), .m_eop1_ptr(m_eop1_ptr)
  );

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int id_q[$], len_q[$];
  int sent = 0, delivered = 0, dual_start = 0, dual_end = 0;
  bit rdy_rand = 0, gap_rand = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int id, int idx);
    return {id[15:0], idx[15:0]};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Drive one packet; called at posedge + 1
  task automatic send_pkt(int id, int len);
    id_q.push_back(id);
    len_q.push_back(len);
    sent++;
    for (int b = 0; b * 16 < len; b++) begin
      int nd;
      nd = len - b * 16;
      if (nd > 16) nd = 16;
      if (gap_rand) begin
        while ($urandom % 4 == 0) begin
          @(posedge clk); #1;
        end
      end
      for (int d = 0; d < 16; d++) begin
        s_tdata[d*32 +: 32] = (d < nd) ? pat(id, b * 16 + d) : 32'h0;
        s_tkeep[d] = (d < nd);
      end
      s_tlast  = ((b + 1) * 16 >= len);
      s_tvalid = 1'b1;
      do @(negedge clk); while (!s_tready);
      @(posedge clk); #1;
      s_tvalid = 1'b0;
    end
  endtask

  task automatic drain(string req);
    int t;
    t = 0;
    while (delivered < sent && t < 5000) begin
      @(posedge clk);
      t++;
    end
    repeat (4) @(posedge clk);
    #1;
    chk(delivered == sent, req, "packets delivered after idle", delivered, sent);
  endtask

  // Output ready driver
  initial begin
    forever begin
      @(posedge clk); #1;
      m_tready = rdy_rand ? ($urandom % 4 != 0) : 1'b1;
    end
  end

  // Reference unpacker and per-beat rule checks, sampled mid-cycle
  bit                in_pkt = 0;
  logic [31:0]       cur[$];
  bit                prev_stall = 0;
  logic [DATA_W-1:0] prev_data;
  logic [28:0]       prev_sb;

  task automatic close_pkt();
    int id, len;
    bit ok;
    if (id_q.size() == 0) begin
      chk(0, "R1", "packet with no matching input", 0, 1);
      return;
    end
    id  = id_q.pop_front();
    len = len_q.pop_front();
    ok  = (cur.size() == len);
    for (int i = 0; i < cur.size() && ok; i++) ok = (cur[i] == pat(id, i));
    chk(ok, "R1", "rebuilt packet length", cur.size(), len);
    delivered++;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall) begin
        chk(m_tvalid && m_tdata == prev_data &&
            {m_tkeep, m_tlast, m_sop, m_eop, m_eop0_ptr, m_eop1_ptr} == prev_sb,
            "R8", "beat changed while stalled", int'(m_tvalid), 1);
      end
      if (m_tvalid && !m_tready) chk(!s_tready, "R8", "input ready during stall", int'(s_tready), 0);
      prev_stall = m_tvalid && !m_tready;
      prev_data  = m_tdata;
      prev_sb    = {m_tkeep, m_tlast, m_sop, m_eop, m_eop0_ptr, m_eop1_ptr};

      if (m_tvalid && m_tready) begin : beat
        bit cont, mid;
        int sa, sb, ea, eb, ecnt, tgt;
        logic [BDW-1:0] ek;
        cont = in_pkt;
        sa = -1; sb = -1;
        if (cont) begin
          if (m_sop[0]) sa = 8;
        end else begin
          if (m_sop[0]) sa = 0;
          if (m_sop[1]) sb = 8;
        end
        ea = m_eop[0] ? int'(m_eop0_ptr) : -1;
        eb = m_eop[1] ? int'(m_eop1_ptr) : -1;
        if (!cont && !m_sop[0]) chk(0, "R1", "beat with no packet", 0, 1);
        if (straddle_en) begin
          chk(m_tkeep == '1 && !m_tlast, "R2", "keep/last in straddle mode",
              int'({m_tkeep, m_tlast}), int'({16'hffff, 1'b0}));
        end else begin
          chk(m_sop[1] == 0 && m_eop[1] == 0, "R7", "second flags in plain mode",
              int'({m_sop[1], m_eop[1]}), 0);
          chk(m_tlast == m_eop[0], "R7", "tlast vs end flag", int'(m_tlast), int'(m_eop[0]));
          ek = '1;
          if (m_eop[0]) for (int d = 0; d < BDW; d++) ek[d] = (d <= ea);
          chk(m_tkeep == ek, "R7", "keep mask", int'(m_tkeep), int'(ek));
          if (m_sop[0]) chk(!cont, "R7", "start not at fresh beat", int'(cont), 0);
        end
        mid = (cont && m_sop[0]) || m_sop[1];
        if (mid) chk(m_eop[0] && ea < 8, "R3", "mid start after late end", ea, 7);
        if (m_sop[1]) begin
          dual_start++;
          chk(m_sop[0] && m_eop[0], "R4", "second start flags", int'({m_sop, m_eop[0]}), 7);
        end
        if (m_eop[1]) begin
          dual_end++;
          chk(m_eop[0] && eb >= 11 && eb <= 15, "R5", "second end pointer", eb, 11);
        end
        ecnt = 0;
        for (int d = 0; d < BDW; d++) begin
          if (d == sa || d == sb) begin
            if (in_pkt) chk(0, "R3", "start inside a packet", d, -1);
            in_pkt = 1;
            cur.delete();
          end
          if (in_pkt) begin
            cur.push_back(m_tdata[d*32 +: 32]);
            tgt = (ecnt == 0) ? ea : eb;
            if (d == tgt) begin
              close_pkt();
              in_pkt = 0;
              ecnt++;
            end
          end
        end
        if (ecnt != int'(m_eop[0]) + int'(m_eop[1]))
          chk(0, "R5", "end flags not matched to packets", ecnt, int'(m_eop[0]) + int'(m_eop[1]));
      end
    end
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d packets", delivered, sent);
    finish_run();
  end

  initial begin
    int lens[$];
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R1", "valid out of reset", int'(m_tvalid), 0);
    @(posedge clk); #1;

    // R6: lone short packet, no successor
    send_pkt(1, 6);
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R6", "tail emitted too early", int'(m_tvalid), 0);
    @(negedge clk);
    chk({m_tvalid, m_sop, m_eop, m_eop0_ptr} == {1'b1, 2'b01, 2'b01, 4'd5}, "R6",
        "lone partial beat", int'({m_tvalid, m_sop, m_eop, m_eop0_ptr}),
        int'({1'b1, 2'b01, 2'b01, 4'd5}));
    @(posedge clk); #1;

    // Straddle patterns: two starts and ends, shifted runs, tails
    lens = '{8, 4, 20, 8, 12, 5, 24, 16, 17, 9, 40, 4, 4, 7, 25, 8, 8};
    foreach (lens[i]) send_pkt(10 + i, lens[i]);
    drain("R6");
    chk(dual_start > 0, "R4", "two-start beats seen", dual_start, 1);
    chk(dual_end > 0, "R5", "two-end beats seen", dual_end, 1);

    rdy_rand = 1;
    gap_rand = 1;
    for (int i = 0; i < 150; i++) send_pkt(100 + i, 4 + int'($urandom % 45));
    drain("R1");

    // Plain mode
    straddle_en = 1'b0;
    rdy_rand = 0;
    gap_rand = 0;
    lens = '{8, 4, 16, 5, 33, 4};
    foreach (lens[i]) send_pkt(300 + i, lens[i]);
    rdy_rand = 1;
    gap_rand = 1;
    for (int i = 0; i < 60; i++) send_pkt(400 + i, 4 + int'($urandom % 45));
    drain("R7");

    finish_run();
  end

endmodule